// File: doc/BRIEF.md
# Contact Bounce Filter

This block cleans a single mechanical contact or encoder channel that is sampled by a fast system clock. The raw level first passes through a two-flop sampler. Whenever the two sampler stages differ, the sampled level has just changed, and that one-cycle change pulse restarts a stability timer. The timer counts up once per clock and saturates at its all-ones value. While it sits at that value, and only then, the clean output register takes the settled sampled level. A bounce burst keeps restarting the timer, so the output moves once, after the contact has held still for a whole window.

The timer is a two-state machine. In COUNTING it increments every cycle. It takes the transition COUNT_DONE to SATURATED when the count reaches its maximum with no change pulse present. It takes the transition RESTART from either state back to COUNTING, with a zero count, when a change pulse arrives. SATURATED acts as the load enable of the output register. The whole design uses one clock: the timer clear and the output load are both synchronous. The window is 2^TIMER_W − 1 cycles. With the default width of 16 and a 50 MHz clock, this is roughly 1.3 ms. Each extra bit doubles it, and a 12-bit timer gives only about 80 µs.

Top module: `bounce_filter`

## Requirements
- R1: While rst_n is low, clean_out is 0, and the sampler, the timer and the output register all reset to zero.
- R2: An input pulse lasting one clock cycle, surrounded by the settled level, never changes clean_out.
- R3: After the input changes and then holds steady, clean_out takes the new level on exactly the (2^TIMER_W + 2)-th rising edge, counting the first edge that samples the new level as edge 1. Before that edge, clean_out keeps the old level.
- R4: Each change of the sampled input restarts the timer from zero (RESTART). An input that keeps toggling with gaps shorter than the window leaves clean_out unchanged.
- R5: Once the timer saturates (SATURATED), it holds its maximum without wrapping, and clean_out stays at the settled level for as long as the input is stable.
- R6: With no change pulse, the timer in COUNTING rises by exactly one per clock. The window length is set only by the parameter TIMER_W (default 16), with a maximum count of 2^TIMER_W − 1.
- R7: Rising and falling input transitions are filtered the same way. clean_out changes only in a cycle after the timer was SATURATED, and only to the settled sampled level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| noisy_in | input | 1 | Raw contact level, asynchronous to clk |
| clean_out | output | 1 | Debounced level |

## Verification
The bench checks the exact edge on which a held level appears at clean_out. A design with an off-by-one in the sampler depth or in the saturation test would move the output one cycle early or late. It drives one-cycle glitches and bursts of toggles spaced just inside the window. A timer that was not cleared on every change, or a load that was not gated by saturation, would let the output flicker there. Long stable stretches after saturation catch a timer that wraps instead of holding, because a wrapped timer would reopen and close the load window. Random bounce patterns with a fixed seed cover both polarities against a cycle model of the requirements.

// File: rtl/bounce_filter_pkg.sv
package bounce_filter_pkg;
    typedef enum logic {
        TMR_COUNTING  = 1'b0,
        TMR_SATURATED = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/bounce_sampler.sv
module bounce_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic change_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    // one-cycle pulse when the newest sample differs from the older one
    assign change_o = stage1_q ^ stage2_q;
    assign level_o  = stage2_q;
endmodule

// File: rtl/stability_timer.sv
module stability_timer
    import bounce_filter_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    output logic [TIMER_W-1:0] count_o,
    output logic               full_o
);
    localparam logic [TIMER_W-1:0] CNT_MAX  = '1;
    localparam logic [TIMER_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    tmr_state_e         state_q;
    tmr_state_e         state_d;
    logic [TIMER_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_COUNTING;
        else        state_q <= state_d;
    end

    // transitions: COUNT_DONE and RESTART
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_COUNTING: begin
                if (!clear_i && cnt_q == CNT_LAST) state_d = TMR_SATURATED;
            end
            TMR_SATURATED: begin
                if (clear_i) state_d = TMR_COUNTING;
            end
            default: state_d = TMR_COUNTING;
        endcase
    end

    // count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clear_i)                   cnt_q <= '0;
        else if (state_q == TMR_COUNTING)   cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
    assign full_o  = (state_q == TMR_SATURATED);
endmodule

// File: rtl/level_hold.sv
module level_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic level_i,
    output logic level_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      level_o <= 1'b0;
        else if (load_i) level_o <= level_i;
    end
endmodule

// File: rtl/bounce_filter.sv
module bounce_filter #(
    parameter int TIMER_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic noisy_in,
    output logic clean_out
);
    logic               sample_lvl;
    logic               change_pulse;
    logic [TIMER_W-1:0] timer_cnt;
    logic               timer_full;

    bounce_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (noisy_in),
        .level_o  (sample_lvl),
        .change_o (change_pulse)
    );

    stability_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (change_pulse),
        .count_o (timer_cnt),
        .full_o  (timer_full)
    );

    level_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (timer_full),
        .level_i (sample_lvl),
        .level_o (clean_out)
    );
endmodule

// File: rtl/bounce_filter_chk.sv
module bounce_filter_chk #(
    parameter int TIMER_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chg,
    input logic [TIMER_W-1:0] cnt,
    input logic               full,
    input logic               lvl,
    input logic               clean_out
);
    localparam logic [TIMER_W-1:0] CNT_MAX = '1;

    always_comb begin
        if (!rst_n) AST_RESET_LOW: assert (clean_out == 1'b0); // R1
    end

    AST_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (cnt == '0)); // R4

    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !chg) |=> (full && cnt == CNT_MAX)); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && !full) |=> (cnt == $past(cnt) + 1'b1)); // R6

    AST_LOAD_ONLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (clean_out == $past(lvl))); // R7

    AST_NO_LOAD_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        !full |=> $stable(clean_out)); // R7
endmodule

bind bounce_filter bounce_filter_chk #(.TIMER_W(TIMER_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg       (change_pulse),
    .cnt       (timer_cnt),
    .full      (timer_full),
    .lvl       (sample_lvl),
    .clean_out (clean_out)
);

// File: tb/sim_bounce_filter.sv
module sim_bounce_filter;
    localparam int TW  = 4;
    localparam int MAX = (1 << TW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic noisy_in = 1'b0;
    logic clean_out;

    int checks = 0;
    int errors = 0;

    // cycle model built from R3..R7
    logic m_s1 = 1'b0, m_s2 = 1'b0, m_out = 1'b0;
    int   m_age = 0;

    bounce_filter #(.TIMER_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .noisy_in(noisy_in), .clean_out(clean_out)
    );

    always #2 clk = ~clk;

    function automatic logic next_out(logic o, int age, logic s2);
        return (age == MAX) ? s2 : o;
    endfunction

    function automatic int next_age(int age, logic s1, logic s2);
        if (s1 != s2) return 0;
        return (age < MAX) ? age + 1 : age;
    endfunction

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update model on posedge, sample at negedge
    task automatic tick(logic v, string req);
        noisy_in = v;
        @(posedge clk);
        m_out = next_out(m_out, m_age, m_s2);
        m_age = next_age(m_age, m_s1, m_s2);
        m_s2  = m_s1;
        m_s1  = v;
        @(negedge clk);
        check(clean_out, m_out, req);
    endtask

    task automatic hold(logic v, int n, string req);
        for (int i = 0; i < n; i++) tick(v, req);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic lvl;
        seed = $urandom(32'h1234);
        // R1: reset state
        repeat (3) @(negedge clk);
        check(clean_out, 1'b0, "R1");
        noisy_in = 1'b1;
        repeat (2) @(negedge clk);
        check(clean_out, 1'b0, "R1 input ignored in reset");
        noisy_in = 1'b0;
        rst_n = 1'b1;
        hold(1'b0, MAX + 4, "R1");

        // R3/R6: exact edge of a rising update
        for (int k = 1; k <= MAX + 3; k++) begin
            tick(1'b1, "R3");
            if (k == MAX + 2) check(clean_out, 1'b0, "R3 not yet");
            if (k == MAX + 3) check(clean_out, 1'b1, "R3 updated");
        end

        // R5: long stable stretch, no wrap
        hold(1'b1, 3 * MAX, "R5");
        check(clean_out, 1'b1, "R5 held");

        // R2: single-cycle glitch ignored
        tick(1'b0, "R2");
        hold(1'b1, 3 * MAX, "R2");
        check(clean_out, 1'b1, "R2 glitch");

        // R4: toggles spaced just inside the window
        lvl = 1'b0;
        for (int b = 0; b < 6; b++) begin
            hold(lvl, MAX, "R4");
            check(clean_out, 1'b1, "R4 bouncing");
            lvl = ~lvl;
        end

        // R7: falling edge timing after bounce ends on 0
        for (int k = 1; k <= MAX + 3; k++) begin
            tick(1'b0, "R7");
            if (k == MAX + 2) check(clean_out, 1'b1, "R7 not yet");
            if (k == MAX + 3) check(clean_out, 1'b0, "R7 updated");
        end

        // random bounce bursts checked against the model (R3, R4, R7)
        for (int r = 0; r < 300; r++) begin
            int len;
            len = 1 + int'($urandom_range(2 * MAX + 4));
            lvl = logic'($urandom_range(1));
            hold(lvl, len, "R4 random");
        end
        hold(lvl, MAX + 4, "R3 random settle");
        check(clean_out, lvl, "R3 random final");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule